// File: doc/BRIEF.md
# Timer with Shared Assignable Prescaler

This block is an 8-bit up-counting timer. It shares one divider between the timer and a watchdog. Software uses a byte-wide mode register to steer the divider to one of the two consumers. The timer counts either the internal instruction-cycle tick or edges on an external clock pin. For the pin, the counted edge can be rising or falling. When the count wraps from its top value to zero, the timer raises a one-cycle overflow pulse and sets a sticky flag. Only an explicit clear input resets the flag.

The divider has two rate tables, selected by where it is assigned. When it serves the timer, the 3-bit rate field divides by two raised to the field plus one. When it serves the watchdog, it divides the watchdog's base ticks by two raised to the field. In that case the timer counts every source tick, so this is the only way to get an undivided timer. The consumer that does not own the divider gets its tick stream passed straight through.

Software clears the divider's partial count in two ways: by loading the count register, or by writing a mode value that moves the divider to the other consumer. After either write, the next division period starts from zero.

Top module: `shared_div_timer`

## Requirements
- R1: After reset the mode register reads 0xFF, the count register reads 0x00 and the overflow flag is 0.
- R2: With mode bit 3 = 0 (divider on the timer), the timer advances once per 2^(rate+1) source ticks, where rate is mode bits [2:0]. This gives 1:2 at rate 0 and 1:256 at rate 7.
- R3: With mode bit 3 = 1 (divider on the watchdog), the timer advances on every source tick and `wdt_tick` fires once per 2^rate `wdt_base_tick` pulses. With bit 3 = 0, every `wdt_base_tick` pulse appears on `wdt_tick`.
- R4: With mode bit 5 = 1, the timer source is the external pin, passed through a two-flop synchronizer. With bit 4 = 0, each low-to-high transition gives exactly one source tick however long the level is held, and `cyc_tick` has no effect. With bit 5 = 0, `cyc_tick` is the source.
- R5: With mode bits 5 = 1 and 4 = 1, only high-to-low transitions of the external pin count. A low-to-high transition leaves the count unchanged.
- R6: An advance from 0xFF to 0x00 gives a one-cycle `ovf_pulse` and sets `ovf_flag`. The flag stays set until `flag_clr` is asserted without a new overflow in the same cycle.
- R7: A write to the count register (`reg_sel` = 0) loads the value and clears the divider's partial count.
- R8: A mode write that changes bit 3 clears the divider's partial count. A mode write that keeps bit 3 leaves the partial count intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = count, 1 = mode |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cyc_tick | input | 1 | Internal instruction-cycle tick |
| ext_clk | input | 1 | External clock pin, asynchronous |
| wdt_base_tick | input | 1 | Undivided watchdog tick |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_tick | output | 1 | Watchdog tick after the divider (or passed through) |
| ovf_pulse | output | 1 | One-cycle pulse on count wrap |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Some properties are checked on every cycle. A timer advance always adds exactly one. The count holds when there is neither an advance nor a write. A wrap pulse always coincides with a zero count and a set flag. The flag never drops without a clear. A divider clear always empties the partial count. A synchronized edge never lasts two cycles.

Only the bench's scenarios can show the rest: the actual division ratios of both rate tables, pass-through to the consumer that does not own the divider, the choice of pin edge, and the fact that a count write or an assignment change restarts the division period while a same-assignment write does not.

// File: rtl/sdt_pkg.sv
// Package: shared types for the shared-divider timer.
// Assumes an 8-bit mode register whose bit positions are fixed by software.
package sdt_pkg;

    localparam int TMR_W  = 8;          // timer width
    localparam int RATE_W = 3;          // rate field width
    localparam int DIV_W  = 2**RATE_W;  // divider counter width (max 1:256)

    // Mode register layout, MSB first; bit positions are software-visible.
    typedef struct packed {
        logic              pull_off;   // [7] stored only
        logic              irq_rise;   // [6] stored only
        logic              src_ext;    // [5] 1 = external pin
        logic              src_fall;   // [4] 1 = count falling edges
        logic              to_wdt;     // [3] 1 = divider on watchdog
        logic [RATE_W-1:0] rate;       // [2:0] rate select
    } mode_t;

    localparam logic [TMR_W-1:0] MODE_RST = 8'hFF;

endpackage

// File: rtl/sdt_edge_sync.sv
// Module: synchronizes the asynchronous external clock pin and turns the
// selected transition into a single-cycle enable.
// Assumes the pin stays at each level for more than STAGES+1 clock cycles.
module sdt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_tick
);

    logic [STAGES:0] shr;
    logic            synced;
    logic            prior;
    logic            rise;
    logic            fall;

    // Purpose: shift the pin through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shr <= '0;
        else        shr <= {shr[STAGES-1:0], pin};
    end

    // Purpose: detect transitions between the synchronized and history bits.
    always_comb begin
        synced    = shr[STAGES-1];
        prior     = shr[STAGES];
        rise      = synced & ~prior;
        fall      = ~synced & prior;
        edge_tick = fall_sel ? fall : rise;
    end

    // R4: a detected edge never lasts two cycles
    a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rise | fall) |=> !(rise | fall) || (synced != $past(synced)));

endmodule

// File: rtl/sdt_prescaler.sv
// Module: the shared divider. It counts the ticks of whichever consumer
// owns it and divides them by the rate table of that consumer. The other
// consumer's ticks pass straight through.
// Assumes the clear has priority over an advance in the same cycle.
module sdt_prescaler #(
    parameter int RATE_W = 3,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    input  logic              src_tick,
    input  logic              wdt_base,
    output logic              tmr_tick,
    output logic              wdt_tick
);

    localparam logic [DIV_W:0] ONE = {{DIV_W{1'b0}}, 1'b1};

    logic [DIV_W-1:0] div_cnt;
    logic [RATE_W:0]  tmr_shift;
    logic [DIV_W:0]   tmr_mask;
    logic [DIV_W:0]   wdt_mask;
    logic             tmr_full;
    logic             wdt_full;
    logic             advance;

    // Purpose: build the masks for both rate tables and test for a full period.
    always_comb begin
        tmr_shift = {1'b0, rate} + {{RATE_W{1'b0}}, 1'b1};
        tmr_mask  = (ONE << tmr_shift) - ONE;
        wdt_mask  = (ONE << rate) - ONE;
        tmr_full  = &(div_cnt | ~tmr_mask[DIV_W-1:0]);
        wdt_full  = &(div_cnt | ~wdt_mask[DIV_W-1:0]);
        advance   = to_wdt ? wdt_base : src_tick;
        tmr_tick  = to_wdt ? src_tick : (src_tick & tmr_full);
        wdt_tick  = to_wdt ? (wdt_base & wdt_full) : wdt_base;
    end

    // Purpose: run the partial count; a clear restarts the period.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cnt <= '0;
        else if (clr)     div_cnt <= '0;
        else if (advance) div_cnt <= div_cnt + {{(DIV_W-1){1'b0}}, 1'b1};
    end

    // R7/R8: a clear always empties the partial count
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_cnt == '0));

    // R3: while the watchdog owns the divider, its ticks never exceed its base
    a_r3_wdt_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (to_wdt && wdt_tick) |-> wdt_base);

endmodule

// File: rtl/sdt_counter.sv
// Module: the 8-bit count register with the wrap pulse and the sticky flag.
// Assumes a software load has priority over an advance in the same cycle.
module sdt_counter #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] count,
    output logic             ovf_pulse,
    output logic             ovf_flag
);

    logic wrap;

    // Purpose: detect an advance from the top value.
    always_comb wrap = tick && !load && (&count);

    // Purpose: load or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (tick) count <= count + {{(TMR_W-1){1'b0}}, 1'b1};
    end

    // Purpose: register the one-cycle wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_pulse <= 1'b0;
        else        ovf_pulse <= wrap;
    end

    // Purpose: hold the sticky flag; a new wrap wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_flag <= 1'b0;
        else if (wrap)     ovf_flag <= 1'b1;
        else if (flag_clr) ovf_flag <= 1'b0;
    end

    // R2: every advance adds exactly one
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (count == $past(count) + {{(TMR_W-1){1'b0}}, 1'b1}));

    // R2: without an advance or a load, the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count));

    // R6: a wrap pulse goes with a zero count and a set flag
    a_r6_pulse_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0) && ovf_flag);

    // R6: the flag drops only on a clear
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

endmodule

// File: rtl/shared_div_timer.sv
// Module: top of the timer with a shared assignable divider. It holds the
// mode register, picks the timer source and produces the divider clear.
// Assumes reg_rdata is read combinationally and a write lands at the next edge.
module shared_div_timer
    import sdt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [TMR_W-1:0] reg_wdata,
    output logic [TMR_W-1:0] reg_rdata,
    input  logic             cyc_tick,
    input  logic             ext_clk,
    input  logic             wdt_base_tick,
    input  logic             flag_clr,
    output logic             wdt_tick,
    output logic             ovf_pulse,
    output logic             ovf_flag
);

    mode_t            mode;
    mode_t            wmode;
    logic [TMR_W-1:0] count;
    logic             ext_tick;
    logic             src_tick;
    logic             tmr_tick;
    logic             cnt_load;
    logic             div_clr;

    // Purpose: hold the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode <= mode_t'(MODE_RST);
        else if (reg_wr && reg_sel) mode <= mode_t'(reg_wdata);
    end

    // Purpose: decode writes, the divider clear, the source and the read mux.
    always_comb begin
        wmode     = mode_t'(reg_wdata);
        cnt_load  = reg_wr && !reg_sel;
        div_clr   = cnt_load || (reg_wr && reg_sel && (wmode.to_wdt != mode.to_wdt));
        src_tick  = mode.src_ext ? ext_tick : cyc_tick;
        reg_rdata = reg_sel ? mode : count;
    end

    sdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin       (ext_clk),
        .fall_sel  (mode.src_fall),
        .edge_tick (ext_tick)
    );

    sdt_prescaler #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (div_clr),
        .to_wdt   (mode.to_wdt),
        .rate     (mode.rate),
        .src_tick (src_tick),
        .wdt_base (wdt_base_tick),
        .tmr_tick (tmr_tick),
        .wdt_tick (wdt_tick)
    );

    sdt_counter #(.TMR_W(TMR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tmr_tick),
        .load      (cnt_load),
        .load_val  (reg_wdata),
        .flag_clr  (flag_clr),
        .count     (count),
        .ovf_pulse (ovf_pulse),
        .ovf_flag  (ovf_flag)
    );

    // R4: internal ticks never reach the timer while the external pin is the source
    a_r4_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.src_ext && !ext_tick) |-> !tmr_tick);

endmodule

// File: tb/test_shared_div_timer.sv
// Bench: scoreboard. Driver tasks push expected items into a queue and a
// monitor pops and compares them on the falling edge.
module test_shared_div_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cyc_tick = 1'b0;
    logic       ext_clk = 1'b0;
    logic       wdt_base_tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic       wdt_tick;
    logic       ovf_pulse;
    logic       ovf_flag;

    typedef struct {
        string req;
        int    kind;   // 0 rdata, 1 flag, 2 wdt tick count, 3 wrap count
        int    val;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   wdt_seen = 0;
    int   ovf_seen = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    shared_div_timer i_shared_div_timer (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_tick(cyc_tick),
        .ext_clk(ext_clk), .wdt_base_tick(wdt_base_tick), .flag_clr(flag_clr),
        .wdt_tick(wdt_tick), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
    );

    // count output events at the edge where the design sees them
    always @(posedge clk) begin
        if (rst_n && wdt_tick)  wdt_seen++;
        if (rst_n && ovf_pulse) ovf_seen++;
    end

    // monitor: pop one expected item per falling edge and compare
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            int   act;
            e = exp_q.pop_front();
            case (e.kind)
                0:       act = int'(reg_rdata);
                1:       act = int'(ovf_flag);
                2:       act = wdt_seen;
                default: act = ovf_seen;
            endcase
            checks++;
            if (act != e.val) begin
                errors++;
                $display("FAIL %s kind %0d actual %0d expected %0d", e.req, e.kind, act, e.val);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic expect_item(string req, int kind, logic sel, int val);
        exp_t e;
        reg_sel = sel;
        e.req = req; e.kind = kind; e.val = val;
        exp_q.push_back(e);
        step(1);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1; step(1); cyc_tick = 1'b0; step(1);
        end
    endtask

    task automatic wdt_pulses(int n);
        for (int i = 0; i < n; i++) begin
            wdt_base_tick = 1'b1; step(1); wdt_base_tick = 1'b0; step(1);
        end
        step(1);
    endtask

    task automatic ext_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1; step(6); ext_clk = 1'b0; step(6);
        end
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        expect_item("R1", 0, 1'b1, 8'hFF);
        expect_item("R1", 0, 1'b0, 0);
        expect_item("R1", 1, 1'b0, 0);

        // R2: rate 0 divides by 2
        wr(1'b1, 8'h00); wr(1'b0, 8'h00);
        ticks(10);
        expect_item("R2", 0, 1'b0, 5);
        // R2: rate 7 divides by 256
        wr(1'b1, 8'h07); wr(1'b0, 8'h00);
        ticks(512);
        expect_item("R2", 0, 1'b0, 2);
        ticks(255);
        expect_item("R2", 0, 1'b0, 2);
        ticks(1);
        expect_item("R2", 0, 1'b0, 3);

        // R3: divider on watchdog, timer counts each tick
        wr(1'b1, 8'h08); wr(1'b0, 8'h00);
        ticks(7);
        expect_item("R3", 0, 1'b0, 7);
        // R3: watchdog divided by 8
        wr(1'b1, 8'h0B); wr(1'b0, 8'h00);
        begin
            int base;
            base = wdt_seen;
            wdt_pulses(7);
            expect_item("R3", 2, 1'b0, base);
            wdt_pulses(1);
            expect_item("R3", 2, 1'b0, base + 1);
            wdt_pulses(16);
            expect_item("R3", 2, 1'b0, base + 3);
            // R3: divider on timer, watchdog passes through
            wr(1'b1, 8'h03);
            base = wdt_seen;
            wdt_pulses(5);
            expect_item("R3", 2, 1'b0, base + 5);
        end

        // R4: rising edges of the pin; cyc_tick held high has no effect
        wr(1'b1, 8'h28); wr(1'b0, 8'h00);
        cyc_tick = 1'b1;
        step(4);
        expect_item("R4", 0, 1'b0, 0);
        ext_pulses(6);
        expect_item("R4", 0, 1'b0, 6);
        cyc_tick = 1'b0;

        // R5: falling edges only
        wr(1'b1, 8'h38); wr(1'b0, 8'h00);
        ext_clk = 1'b1; step(6);
        expect_item("R5", 0, 1'b0, 0);
        ext_clk = 1'b0; step(6);
        expect_item("R5", 0, 1'b0, 1);
        ext_pulses(3);
        expect_item("R5", 0, 1'b0, 4);

        // R6: wrap pulse and sticky flag
        wr(1'b1, 8'h08); wr(1'b0, 8'hFE);
        begin
            int obase;
            obase = ovf_seen;
            ticks(1);
            expect_item("R6", 0, 1'b0, 8'hFF);
            expect_item("R6", 1, 1'b0, 0);
            ticks(1);
            step(1);
            expect_item("R6", 0, 1'b0, 0);
            expect_item("R6", 1, 1'b0, 1);
            expect_item("R6", 3, 1'b0, obase + 1);
            ticks(3);
            expect_item("R6", 1, 1'b0, 1);
            expect_item("R6", 3, 1'b0, obase + 1);
        end
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        expect_item("R6", 1, 1'b0, 0);

        // R7: count write restarts the division period (rate 1 = 1:4)
        wr(1'b1, 8'h01); wr(1'b0, 8'h00);
        ticks(3);
        expect_item("R7", 0, 1'b0, 0);
        wr(1'b0, 8'h10);
        ticks(3);
        expect_item("R7", 0, 1'b0, 8'h10);
        ticks(1);
        expect_item("R7", 0, 1'b0, 8'h11);

        // R8: assignment change clears; same-assignment write keeps the count
        wr(1'b0, 8'h00);
        ticks(3);
        wr(1'b1, 8'h09); wr(1'b1, 8'h01);
        ticks(3);
        expect_item("R8", 0, 1'b0, 0);
        ticks(1);
        expect_item("R8", 0, 1'b0, 1);
        ticks(3);
        wr(1'b1, 8'h01);
        ticks(1);
        expect_item("R8", 0, 1'b0, 2);

        step(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule